// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer with Automatic Sleep

This block is the digital control for a 10-bit successive-approximation converter. A falling edge on the active-low start input puts the external sample capacitor into hold. The block then searches for the code one bit at a time, from the most significant bit down. On each step it drives a trial code to an external DAC and reads back one comparator decision. The search is paced by a free-running internal clock. It takes one setup cycle and then one cycle per bit.

When the last bit is decided, the block samples the level of the start input. A low level sends the block to sleep. A high level keeps it powered, so the next conversion can begin at once. A rising edge on the start input has two effects. It opens the serial port, so that several converters can share one data line. When the block is asleep, the same edge also starts a timed wake-up. Once the port is open, the result leaves MSB first, one bit per rising edge of the external serial clock. The output drive turns off after the falling serial-clock edge that follows the last bit.

Top module: `sar_seq`

## Requirements
- R1: After reset, `pwr_dn_o` is 1, and `busy_o`, `hold_o`, `dout_en_o` and `dout_o` are 0.
- R2: While asleep, a falling start edge is ignored. A rising start edge drops `pwr_dn_o` in the next cycle. The block then waits a wake time of WAKE_CYC cycles (ceil(WAKE_NS*1000/CLK_PERIOD_PS), 375 by default) before it accepts a start.
- R3: A falling start edge while the block is powered and idle raises `busy_o` and `hold_o` in the next cycle. Both stay high for exactly W+1 (11) cycles.
- R4: In the first conversion cycle `dac_code_o` is 0. In each later cycle it is the bits kept so far, with the current trial bit set. The trial bit goes from bit 9 down to bit 0. A trial bit is kept when `cmp_i` is 1 at the end of its cycle, where 1 means input >= DAC code.
- R5: After a conversion, the result equals the input code for every code, including 0 and 1023.
- R6: When a conversion ends, a low start level puts the block to sleep (`pwr_dn_o`=1). A high level leaves it powered and idle (`pwr_dn_o`=0).
- R7: A falling start edge during a conversion is ignored. It does not lengthen or restart the conversion.
- R8: A rising start edge opens the port. `dout_en_o` is high whenever the port is open and no conversion is running. Each SCLK rising edge then presents the next result bit on `dout_o`, MSB first. `dout_o` is 0 before the first bit.
- R9: The SCLK falling edge after the 10th bit closes the port. `dout_en_o` drops to 0 in the next cycle.
- R10: SCLK edges are ignored while the port is closed or a conversion is running. `dout_o` stays 0 while the port is closed, and a later read still returns all 10 bits from the MSB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal conversion clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnv_n_i | input | 1 | Start input, active low; its level at end of conversion selects sleep |
| cmp_i | input | 1 | Comparator decision, 1 when input >= DAC code |
| sclk_i | input | 1 | External serial clock |
| dac_code_o | output | 10 | Trial code, or the result when no conversion is running |
| hold_o | output | 1 | Sample capacitor in hold |
| busy_o | output | 1 | Conversion running |
| pwr_dn_o | output | 1 | Block asleep |
| dout_o | output | 1 | Serial result bit |
| dout_en_o | output | 1 | Serial output drive enable; 0 means high impedance |

## Verification
The assertions assume that `cnv_n_i` and `sclk_i` change away from the active clock edge. They also assume that each level of these inputs lasts at least one clock, so that every edge is seen as one sampled transition. The bench drives both inputs on the falling clock edge and holds each SCLK phase for several cycles. It models the comparator as a combinational compare of a fixed input code against `dac_code_o`, and it changes that code only while no conversion is running. A start pulse that comes back high during a conversion is the only case where a rising edge overlaps the search. It is exercised on purpose.

// File: rtl/sar_seq_pkg.sv
`timescale 1ns/1ps
package sar_seq_pkg;
  typedef enum logic [1:0] {
    ST_PDOWN = 2'd0,
    ST_WAKE  = 2'd1,
    ST_IDLE  = 2'd2,
    ST_CONV  = 2'd3
  } seq_state_e;
endpackage

// File: rtl/sar_seq_ctrl.sv
`timescale 1ns/1ps
module sar_seq_ctrl
  import sar_seq_pkg::*;
#(
  parameter int unsigned W        = 10,
  parameter int unsigned WAKE_CYC = 375
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cnv_n_i,
  output seq_state_e state_o,
  output logic       clr_o,
  output logic       load_o,
  output logic       step_o,
  output logic       cnv_rise_o
);
  localparam int unsigned CW  = $clog2(W + 1);
  localparam int unsigned WCW = $clog2(WAKE_CYC + 1);

  seq_state_e     state_q;
  logic [CW-1:0]  cnt_q;
  logic [WCW-1:0] wcnt_q;
  logic           cnv_q;
  logic           fall_w, rise_w;

  assign fall_w = cnv_q & ~cnv_n_i;
  assign rise_w = ~cnv_q & cnv_n_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_PDOWN;
      cnt_q   <= '0;
      wcnt_q  <= '0;
      cnv_q   <= 1'b1;
    end else begin
      cnv_q <= cnv_n_i;
      unique case (state_q)
        ST_PDOWN: if (rise_w) begin
          state_q <= ST_WAKE;
          wcnt_q  <= '0;
        end
        ST_WAKE: begin
          if (wcnt_q == WCW'(WAKE_CYC - 1)) state_q <= ST_IDLE;
          else                              wcnt_q  <= wcnt_q + 1'b1;
        end
        ST_IDLE: if (fall_w) begin
          state_q <= ST_CONV;
          cnt_q   <= '0;
        end
        ST_CONV: begin
          // start level at the last decision selects sleep or stay awake
          if (cnt_q == CW'(W)) state_q <= cnv_n_i ? ST_IDLE : ST_PDOWN;
          else                 cnt_q   <= cnt_q + 1'b1;
        end
        default: state_q <= ST_PDOWN;
      endcase
    end
  end

  assign state_o    = state_q;
  assign clr_o      = (state_q == ST_IDLE) && fall_w;
  assign load_o     = (state_q == ST_CONV) && (cnt_q == '0);
  assign step_o     = (state_q == ST_CONV) && (cnt_q != '0);
  assign cnv_rise_o = rise_w;
endmodule

// File: rtl/sar_seq_search.sv
`timescale 1ns/1ps
module sar_seq_search #(
  parameter int unsigned W = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         load_i,
  input  logic         step_i,
  input  logic         cmp_i,
  output logic [W-1:0] result_o,
  output logic [W-1:0] trial_o
);
  logic [W-1:0] sar_q, mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sar_q  <= '0;
      mask_q <= '0;
    end else if (clr_i) begin
      sar_q  <= '0;
      mask_q <= '0;
    end else if (load_i) begin
      mask_q <= {1'b1, {(W-1){1'b0}}};
    end else if (step_i) begin
      if (cmp_i) sar_q <= sar_q | mask_q;
      mask_q <= mask_q >> 1;
    end
  end

  assign result_o = sar_q;
  assign trial_o  = sar_q | mask_q;
endmodule

// File: rtl/sar_seq_shift.sv
`timescale 1ns/1ps
module sar_seq_shift #(
  parameter int unsigned W = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sclk_i,
  input  logic         open_i,
  input  logic         busy_i,
  input  logic [W-1:0] result_i,
  output logic         dout_o,
  output logic         dout_en_o
);
  localparam int unsigned PW = $clog2(W + 1);

  logic          sclk_q, en_q;
  logic [PW-1:0] ptr_q;
  logic [W:0]    sel_w;
  logic          srise_w, sfall_w, act_w;

  assign srise_w = sclk_i & ~sclk_q;
  assign sfall_w = ~sclk_i & sclk_q;
  assign act_w   = en_q & ~busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b0;
      en_q   <= 1'b0;
      ptr_q  <= '0;
    end else begin
      sclk_q <= sclk_i;
      if (open_i) begin
        en_q  <= 1'b1;
        ptr_q <= '0;
      end else if (act_w) begin
        if (srise_w && ptr_q != PW'(W)) ptr_q <= ptr_q + 1'b1;
        else if (sfall_w && ptr_q == PW'(W)) begin
          en_q  <= 1'b0;
          ptr_q <= '0;
        end
      end
    end
  end

  // one-hot selector: ptr 0 points above the MSB, i.e. no bit yet
  assign sel_w     = {1'b1, {W{1'b0}}} >> ptr_q;
  assign dout_o    = act_w & |(sel_w[W-1:0] & result_i);
  assign dout_en_o = act_w;
endmodule

// File: rtl/sar_seq.sv
`timescale 1ns/1ps
module sar_seq
  import sar_seq_pkg::*;
#(
  parameter int unsigned W             = 10,
  parameter int unsigned CLK_PERIOD_PS = 4000,
  parameter int unsigned WAKE_NS       = 1500
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cnv_n_i,
  input  logic         cmp_i,
  input  logic         sclk_i,
  output logic [W-1:0] dac_code_o,
  output logic         hold_o,
  output logic         busy_o,
  output logic         pwr_dn_o,
  output logic         dout_o,
  output logic         dout_en_o
);
  localparam int unsigned WAKE_RAW = (WAKE_NS * 1000 + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
  localparam int unsigned WAKE_CYC = (WAKE_RAW == 0) ? 1 : WAKE_RAW;

  seq_state_e   state_w;
  logic         clr_w, load_w, step_w, rise_w, busy_w;
  logic [W-1:0] result_w;

  sar_seq_ctrl #(.W(W), .WAKE_CYC(WAKE_CYC)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cnv_n_i    (cnv_n_i),
    .state_o    (state_w),
    .clr_o      (clr_w),
    .load_o     (load_w),
    .step_o     (step_w),
    .cnv_rise_o (rise_w)
  );

  sar_seq_search #(.W(W)) u_search (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (clr_w),
    .load_i   (load_w),
    .step_i   (step_w),
    .cmp_i    (cmp_i),
    .result_o (result_w),
    .trial_o  (dac_code_o)
  );

  assign busy_w = (state_w == ST_CONV);

  sar_seq_shift #(.W(W)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sclk_i    (sclk_i),
    .open_i    (rise_w),
    .busy_i    (busy_w),
    .result_i  (result_w),
    .dout_o    (dout_o),
    .dout_en_o (dout_en_o)
  );

  assign busy_o   = busy_w;
  assign hold_o   = busy_w;
  assign pwr_dn_o = (state_w == ST_PDOWN);
endmodule

// File: rtl/sar_seq_chk.sv
`timescale 1ns/1ps
module sar_seq_chk #(
  parameter int unsigned W = 10
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         cnv_n_i,
  input logic         sclk_i,
  input logic [W-1:0] dac_code_o,
  input logic         busy_o,
  input logic         pwr_dn_o,
  input logic         dout_o,
  input logic         dout_en_o
);
  logic [7:0] blen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     blen_q <= '0;
    else if (busy_o) blen_q <= blen_q + 1'b1;
    else             blen_q <= '0;
  end

  // R2
  asleep_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_dn_o |-> !busy_o);

  // R2
  wake_on_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pwr_dn_o) |-> ($past(cnv_n_i) && !$past(cnv_n_i, 2)));

  // R3
  start_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> !$past(cnv_n_i));

  // R7
  conv_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (blen_q == 8'(W + 1)));

  // R6
  end_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (pwr_dn_o == !$past(cnv_n_i)));

  // R9
  port_close_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(dout_en_o) && !busy_o) |-> !$past(sclk_i));

  // R10
  quiet_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dout_en_o |-> !dout_o);

  // R4
  first_trial_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (dac_code_o == '0));
endmodule

bind sar_seq sar_seq_chk #(.W(W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cnv_n_i    (cnv_n_i),
  .sclk_i     (sclk_i),
  .dac_code_o (dac_code_o),
  .busy_o     (busy_o),
  .pwr_dn_o   (pwr_dn_o),
  .dout_o     (dout_o),
  .dout_en_o  (dout_en_o)
);

// File: tb/sar_seq_tb_top.sv
`timescale 1ns/1ps
module sar_seq_tb_top;
  localparam int WAKE = 375;  // 1500 ns at 4 ns

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cnv_n = 1'b1;
  logic       sclk = 1'b0;
  logic       cmp;
  logic [9:0] dac;
  logic       hold, busy, pwr_dn, dout, dout_en;
  int         vin = 0;
  int         n_run = 0, n_fail = 0;
  int         last_blen = 0, blen = 0;
  bit         done = 0;

  always #2 clk = ~clk;

  sar_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cnv_n_i(cnv_n), .cmp_i(cmp), .sclk_i(sclk),
    .dac_code_o(dac), .hold_o(hold), .busy_o(busy), .pwr_dn_o(pwr_dn),
    .dout_o(dout), .dout_en_o(dout_en)
  );

  assign cmp = (vin >= int'(dac));

  task automatic chk(string tag, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // reference model: 0 asleep, 1 waking, 2 idle, 3 converting
  int m_st, m_w, m_cnt, m_code, m_mask, m_ptr;
  bit m_en, m_cp, m_sp;

  always @(posedge clk or negedge rst_n) begin
    bit fall, rise, sr, sf, was_busy;
    if (!rst_n) begin
      m_st <= 0; m_w <= 0; m_cnt <= 0; m_code <= 0; m_mask <= 0;
      m_ptr <= 0; m_en <= 0; m_cp <= 1; m_sp <= 0;
    end else begin
      fall = m_cp && !cnv_n;
      rise = !m_cp && cnv_n;
      sr = sclk && !m_sp;
      sf = !sclk && m_sp;
      was_busy = (m_st == 3);
      case (m_st)
        0: if (rise) begin m_st <= 1; m_w <= 0; end
        1: if (m_w == WAKE - 1) m_st <= 2; else m_w <= m_w + 1;
        2: if (fall) begin m_st <= 3; m_cnt <= 0; m_code <= 0; m_mask <= 0; end
        default: begin
          if (m_cnt == 0) begin
            m_mask <= 512;
            m_cnt <= 1;
          end else begin
            if (vin >= (m_code | m_mask)) m_code <= m_code | m_mask;
            m_mask <= m_mask >> 1;
            if (m_cnt == 10) m_st <= cnv_n ? 2 : 0;
            else m_cnt <= m_cnt + 1;
          end
        end
      endcase
      if (rise) begin
        m_en <= 1; m_ptr <= 0;
      end else if (m_en && !was_busy) begin
        if (sr && m_ptr < 10) m_ptr <= m_ptr + 1;
        else if (sf && m_ptr == 10) begin m_en <= 0; m_ptr <= 0; end
      end
      m_cp <= cnv_n;
      m_sp <= sclk;
    end
  end

  // per-cycle compare, plus busy-length measurement
  always @(posedge clk) begin
    bit mb;
    int md;
    #1;
    if (rst_n && !done) begin
      mb = (m_st == 3);
      md = (m_en && !mb && m_ptr != 0) ? ((m_code >> (10 - m_ptr)) & 1) : 0;
      chk("model R3 busy", busy, mb);
      chk("model R3 hold", hold, mb);
      chk("model R2 pwr_dn", pwr_dn, m_st == 0);
      chk("model R4 dac", dac, m_code | m_mask);
      chk("model R8 dout_en", dout_en, m_en && !mb);
      chk("model R8 dout", dout, md);
      if (busy) blen++;
      else if (blen != 0) begin last_blen = blen; blen = 0; end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic read_word(output int w);
    w = 0;
    for (int i = 0; i < 10; i++) begin
      sclk = 1'b1; tick(3);
      w = (w << 1) | int'(dout);
      sclk = 1'b0; tick(3);
    end
  endtask

  task automatic do_conv(int v, bit end_low, bit extra_fall, bit sclk_mid);
    int w;
    vin = v;
    cnv_n = 1'b0; tick(1);
    chk("R3 busy after fall", busy, 1);
    chk("R3 hold after fall", hold, 1);
    chk("R4 setup code", dac, 0);
    if (!end_low) cnv_n = 1'b1;
    tick(1);
    chk("R4 msb trial", dac, 512);
    if (extra_fall && !end_low) begin
      cnv_n = 1'b0; tick(1); cnv_n = 1'b1;
    end
    if (sclk_mid) begin
      for (int k = 0; k < 2; k++) begin
        sclk = 1'b1; tick(2); sclk = 1'b0; tick(2);
      end
    end
    while (busy) tick(1);
    chk("R7 busy length", last_blen, 11);
    chk("R6 end mode", pwr_dn, end_low);
    if (end_low) begin
      cnv_n = 1'b1; tick(1);
      chk("R2 wake on rise", pwr_dn, 0);
    end
    tick(1);
    chk("R8 port open", dout_en, 1);
    chk("R8 no bit yet", dout, 0);
    read_word(w);
    chk("R5 result", w, v);
    chk("R9 port closed", dout_en, 0);
    if (end_low) tick(WAKE + 10);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    chk("R1 pwr_dn", pwr_dn, 1);
    chk("R1 busy", busy, 0);
    chk("R1 hold", hold, 0);
    chk("R1 dout_en", dout_en, 0);
    chk("R1 dout", dout, 0);
    // fall while asleep ignored, rise wakes
    cnv_n = 1'b0; tick(2);
    chk("R2 fall ignored asleep", busy, 0);
    chk("R2 still asleep", pwr_dn, 1);
    cnv_n = 1'b1; tick(1);
    chk("R2 waking", pwr_dn, 0);
    cnv_n = 1'b0; tick(2);
    chk("R2 fall ignored waking", busy, 0);
    cnv_n = 1'b1;
    tick(WAKE + 5);
    // close the port opened by the wake-up rises
    for (int i = 0; i < 10; i++) begin
      sclk = 1'b1; tick(2); sclk = 1'b0; tick(2);
    end
    chk("R9 closed after drain", dout_en, 0);
    do_conv(0, 0, 0, 0);
    do_conv(1023, 0, 0, 0);
    do_conv(512, 0, 1, 0);
    do_conv(341, 0, 0, 1);
    do_conv(682, 1, 0, 0);
    do_conv(1, 0, 0, 0);
    do_conv(511, 1, 0, 0);
    // SCLK with port closed
    for (int i = 0; i < 3; i++) begin
      sclk = 1'b1; tick(2);
      chk("R10 closed dout", dout, 0);
      chk("R10 closed enable", dout_en, 0);
      sclk = 1'b0; tick(2);
    end
    do_conv(777, 0, 0, 1);
    tick(5);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog R3 act=%0d exp=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule